// File: doc/BRIEF.md
# Predicated Vector Boolean-Invert Unit

This block takes a vector of parameterised width, splits it into lanes of 8, 16, 32 or 64 bits chosen by a two-bit width code, and applies a canonical boolean NOT to each lane. A lane whose source value is zero produces the value 1, zero-extended to the lane width. A lane with any nonzero source value produces zero. A per-byte predicate mask decides which lanes are live. Lanes that are not live either keep the old destination contents (merge mode) or are forced to zero (clear mode).

The caller presents the source vector, the old destination vector, the mask, the width code and the mode together with a one-cycle input strobe. The result is registered. It appears on the clock after the strobe and is marked by a one-cycle output strobe.

Top module: `vbool_inv`

## Requirements
- R1: Lane width in bits is 8 << wcode, where wcode is the 2-bit input with 0=8, 1=16, 2=32 and 3=64. The number of lanes is VLEN divided by the lane width.
- R2: A lane e is live when mask bit e*(width/8) is 1. The other mask bits that fall in that lane have no effect.
- R3: A live lane whose source value is zero produces the value 1 in its least significant bit, with all higher bits of the lane zero.
- R4: A live lane whose source value is nonzero produces all zeros.
- R5: When keep_old=1 (merge mode), a lane that is not live carries the matching bits of old_vec.
- R6: When keep_old=0 (clear mode), a lane that is not live is all zeros.
- R7: When no lane is live, the output equals old_vec in merge mode and all zeros in clear mode, whatever the source value.
- R8: res_vec and res_vld are updated one clock after in_vld=1. res_vld is high for exactly that one cycle. Without in_vld, res_vec holds its value.
- R9: A synchronous active-high reset drives res_vld low and res_vec to zero.
- R10: wcode and keep_old are sampled only in the cycle where in_vld=1. Changing them between strobes leaves the output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input strobe |
| wcode | input | 2 | Lane width code |
| keep_old | input | 1 | 1 = merge mode, 0 = clear mode |
| src_vec | input | VLEN | Source vector |
| old_vec | input | VLEN | Old destination vector |
| mask | input | VLEN/8 | Predicate mask, one bit per byte |
| res_vec | output | VLEN | Registered result |
| res_vld | output | 1 | Result strobe |

## Verification
Random data almost never gives an all-zero lane, and lanes of 32 or 64 bits are the least likely to be zero. The stimulus therefore zeroes each source lane on purpose with a high probability, so that the "produces 1" path of R3 is exercised at every width. A random mask almost never has the bit that controls a lane set to one value while the other bits in that lane hold the opposite value. So the bench runs directed cases where a lane's controlling bit and its ignored bits disagree in both directions. It also runs cases with an all-zero mask, and cases where wcode and keep_old change between strobes.

// File: rtl/vbool_inv_pkg.sv
package vbool_inv_pkg;
   typedef enum logic [1:0] {
      W8  = 2'd0,
      W16 = 2'd1,
      W32 = 2'd2,
      W64 = 2'd3
   } wcode_t;

   localparam int NUM_WIDTHS = 4;

   function automatic int lane_bits(input int code);
      return 8 << code;
   endfunction
endpackage

// File: rtl/vbool_lane_calc.sv
// One fixed-width variant: turns every lane of this width into its canonical boolean NOT.
module vbool_lane_calc #(
   parameter int VLEN  = 256,
   parameter int LBITS = 8
) (
   input  logic [VLEN-1:0]   src,
   input  logic [VLEN/8-1:0] mask,
   input  logic [VLEN-1:0]   old,
   input  logic              keep,
   output logic [VLEN-1:0]   res
);
   localparam int NLANE = VLEN / LBITS;
   localparam int MSTEP = LBITS / 8;

   initial begin
      if (VLEN % LBITS != 0) $error("VLEN must be a multiple of the lane width");
   end

   for (genvar e = 0; e < NLANE; e++) begin : g_lane
      logic live;
      logic is_zero;
      logic [LBITS-1:0] inv;
      assign live    = mask[e*MSTEP];
      assign is_zero = (src[e*LBITS +: LBITS] == '0);
      assign inv     = {{(LBITS-1){1'b0}}, is_zero};
      assign res[e*LBITS +: LBITS] = live ? inv
                                   : (keep ? old[e*LBITS +: LBITS] : '0);
   end
endmodule

// File: rtl/vbool_width_mux.sv
// Builds one lane-calc variant per width and picks one output by the width code.
module vbool_width_mux
   import vbool_inv_pkg::*;
#(
   parameter int VLEN = 256
) (
   input  logic [VLEN-1:0]   src,
   input  logic [VLEN/8-1:0] mask,
   input  logic [VLEN-1:0]   old,
   input  logic              keep,
   input  logic [1:0]        wcode,
   output logic [VLEN-1:0]   res
);
   logic [VLEN-1:0] cand [NUM_WIDTHS];

   for (genvar w = 0; w < NUM_WIDTHS; w++) begin : g_w
      vbool_lane_calc #(.VLEN(VLEN), .LBITS(8 << w)) u_calc (
         .src (src),
         .mask(mask),
         .old (old),
         .keep(keep),
         .res (cand[w])
      );
   end

   assign res = cand[wcode];
endmodule

// File: rtl/vbool_inv.sv
module vbool_inv
   import vbool_inv_pkg::*;
#(
   parameter int VLEN = 256
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_vld,
   input  logic [1:0]        wcode,
   input  logic              keep_old,
   input  logic [VLEN-1:0]   src_vec,
   input  logic [VLEN-1:0]   old_vec,
   input  logic [VLEN/8-1:0] mask,
   output logic [VLEN-1:0]   res_vec,
   output logic              res_vld
);
   localparam int MBITS = VLEN / 8;

   initial begin
      if (VLEN % 64 != 0 || VLEN < 64) $error("VLEN must be a positive multiple of 64");
   end

   logic            any_live;
   logic [VLEN-1:0] src_eff;
   logic [VLEN-1:0] nxt;
   logic [VLEN-1:0] res_q;
   logic            vld_q;

   // Which mask bits matter depends on the width; OR only the bits that control a lane.
   always_comb begin
      any_live = 1'b0;
      for (int b = 0; b < MBITS; b++) begin
         if ((b % (lane_bits(int'(wcode)) / 8)) == 0 && mask[b]) any_live = 1'b1;
      end
   end

   // An all-inactive mask means the source is treated as zero.
   assign src_eff = any_live ? src_vec : '0;

   vbool_width_mux #(.VLEN(VLEN)) u_mux (
      .src  (src_eff),
      .mask (mask),
      .old  (old_vec),
      .keep (keep_old),
      .wcode(wcode),
      .res  (nxt)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_q <= 1'b0;
         res_q <= '0;
      end else begin
         vld_q <= in_vld;
         if (in_vld) res_q <= nxt;
      end
   end

   assign res_vec = res_q;
   assign res_vld = vld_q;

   // R8: the result strobe follows the input strobe by one clock
   a_r8_vld_follows: assert property (@(posedge clk) disable iff (rst) in_vld |=> res_vld)
      else $error("R8 strobe missing");
   // R8: the strobe does not appear without an input strobe
   a_r8_vld_only: assert property (@(posedge clk) disable iff (rst) !in_vld |=> !res_vld)
      else $error("R8 spurious strobe");
   // R8/R10: the result holds between strobes
   a_r10_hold: assert property (@(posedge clk) disable iff (rst) !in_vld |=> $stable(res_vec))
      else $error("R10 result changed without strobe");
   // R6: clear mode with no live lane gives zero
   a_r6_clear_empty: assert property (@(posedge clk) disable iff (rst)
      (in_vld && !keep_old && !any_live) |=> (res_vec == '0))
      else $error("R6 nonzero result");
   // R5: merge mode with no live lane passes the old vector through
   a_r5_merge_empty: assert property (@(posedge clk) disable iff (rst)
      (in_vld && keep_old && !any_live) |=> (res_vec == $past(old_vec)))
      else $error("R5 merge mismatch");
   // R9: reset clears the strobe
   a_r9_reset: assert property (@(posedge clk) rst |=> !res_vld)
      else $error("R9 strobe after reset");
endmodule

// File: tb/vbool_inv_tb.sv
`timescale 1ns/1ps
module vbool_inv_tb;
   localparam int VLEN  = 256;
   localparam int MBITS = VLEN / 8;

   logic              clk = 1'b0;
   logic              rst;
   logic              in_vld;
   logic [1:0]        wcode;
   logic              keep_old;
   logic [VLEN-1:0]   src_vec;
   logic [VLEN-1:0]   old_vec;
   logic [MBITS-1:0]  mask;
   logic [VLEN-1:0]   res_vec;
   logic              res_vld;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   vbool_inv #(.VLEN(VLEN)) u_dut (
      .clk(clk), .rst(rst), .in_vld(in_vld), .wcode(wcode), .keep_old(keep_old),
      .src_vec(src_vec), .old_vec(old_vec), .mask(mask),
      .res_vec(res_vec), .res_vld(res_vld)
   );

   // Reference model written from the requirements (R1-style loop over lanes).
   function automatic logic [VLEN-1:0] ref_model(input logic [1:0] wc, input logic kp,
         input logic [VLEN-1:0] s, input logic [VLEN-1:0] o, input logic [MBITS-1:0] m);
      logic [VLEN-1:0] r;
      int lb;
      int nl;
      bit any;
      lb  = 8 << wc;
      nl  = VLEN / lb;
      r   = kp ? o : '0;
      any = 1'b0;
      for (int e = 0; e < nl; e++) if (m[e*(lb/8)]) any = 1'b1;
      for (int e = 0; e < nl; e++) begin
         if (m[e*(lb/8)]) begin
            bit z;
            z = 1'b1;
            if (any) for (int b = 0; b < lb; b++) if (s[e*lb+b]) z = 1'b0;
            for (int b = 0; b < lb; b++) r[e*lb+b] = (b == 0) ? z : 1'b0;
         end
      end
      return r;
   endfunction

   task automatic check(input string req, input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic check_bit(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%b exp=%b", req, act, exp);
      end
   endtask

   // Apply one operation; sample the result on the following falling edge.
   task automatic run_op(input string req, input logic [1:0] wc, input logic kp,
         input logic [VLEN-1:0] s, input logic [VLEN-1:0] o, input logic [MBITS-1:0] m);
      logic [VLEN-1:0] exp;
      exp = ref_model(wc, kp, s, o, m);
      wcode = wc; keep_old = kp; src_vec = s; old_vec = o; mask = m; in_vld = 1'b1;
      @(negedge clk);
      in_vld = 1'b0;
      check_bit({req, " vld"}, res_vld, 1'b1);
      check(req, res_vec, exp);
   endtask

   function automatic logic [VLEN-1:0] rnd_vec();
      logic [VLEN-1:0] v;
      for (int i = 0; i < VLEN/32; i++) v[i*32 +: 32] = $urandom;
      return v;
   endfunction

   initial begin
      logic [VLEN-1:0] s;
      logic [VLEN-1:0] o;
      logic [VLEN-1:0] held;
      logic [MBITS-1:0] m;
      void'($urandom(32'h5eed_1234));
      rst = 1'b1; in_vld = 1'b0; wcode = 2'd0; keep_old = 1'b0;
      src_vec = '0; old_vec = '0; mask = '0;
      repeat (3) @(negedge clk);
      // R9 reset state
      check_bit("R9 vld", res_vld, 1'b0);
      check("R9 res", res_vec, '0);
      rst = 1'b0;
      @(negedge clk);

      // R3/R4 all lanes live at each width
      for (int w = 0; w < 4; w++) begin
         s = rnd_vec();
         s[15:0] = '0;
         run_op("R3 R4 R1 all-live", 2'(w), 1'b0, s, rnd_vec(), '1);
      end
      // R7 empty mask, both modes
      run_op("R7 R5 empty merge", 2'd1, 1'b1, rnd_vec(), rnd_vec(), '0);
      run_op("R7 R6 empty clear", 2'd3, 1'b0, '0, rnd_vec(), '0);
      // R2 controlling bit clear, others set: lane is not live
      m = '1;
      for (int e = 0; e < 4; e++) m[e*8] = 1'b0;
      run_op("R2 ignored bits high", 2'd3, 1'b1, '0, rnd_vec(), m);
      // R2 controlling bit set, others clear
      m = '0;
      for (int e = 0; e < 4; e++) m[e*8] = 1'b1;
      run_op("R2 ignored bits low", 2'd3, 1'b0, '0, rnd_vec(), m);
      // R2 the same mask reinterpreted at 16-bit lanes
      m = 32'h0000_0101;
      run_op("R2 R1 w16 mask", 2'd1, 1'b1, '0, rnd_vec(), m);
      // R5/R6 alternating mask
      run_op("R5 alt merge", 2'd2, 1'b1, rnd_vec(), rnd_vec(), 32'h0F0F_0F0F);
      run_op("R6 alt clear", 2'd0, 1'b0, rnd_vec(), rnd_vec(), 32'h5555_5555);

      // R10/R8 change mode and width with no strobe: output must hold
      held = res_vec;
      wcode = 2'd3; keep_old = 1'b1; src_vec = rnd_vec(); old_vec = rnd_vec(); mask = '1;
      repeat (3) @(negedge clk);
      check("R10 hold", res_vec, held);
      check_bit("R8 no strobe", res_vld, 1'b0);

      // Random mix of widths, modes and sources with many zero lanes (R3 R4 R5 R6)
      for (int t = 0; t < 300; t++) begin
         logic [1:0] wc;
         int lb;
         wc = 2'($urandom_range(0, 3));
         lb = 8 << wc;
         s = rnd_vec();
         for (int e = 0; e < VLEN/lb; e++)
            if ($urandom_range(0, 2) == 0)
               for (int b = 0; b < lb; b++) s[e*lb+b] = 1'b0;
         o = rnd_vec();
         m = ($urandom_range(0, 9) == 0) ? '0 : MBITS'($urandom);
         run_op("R3 R4 R5 R6 random", wc, 1'($urandom), s, o, m);
         if ($urandom_range(0, 1) == 1) begin
            @(negedge clk);
            check_bit("R8 single pulse", res_vld, 1'b0);
         end
      end

      // R9 reset mid-run
      run_op("R4 before reset", 2'd0, 1'b1, '1, rnd_vec(), '1);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check_bit("R9 vld after reset", res_vld, 1'b0);
      check("R9 res after reset", res_vec, '0);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (50000) @(posedge clk);
            checks++;
            fails++;
            $display("FAIL watchdog act=timeout exp=done");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule